// File: doc/BRIEF.md
# Tick Compare Timer

A 63-bit tick counter that runs whenever its count enable is high, paired with a compare limit that raises a one-cycle soft-interrupt set pulse when the counter reaches it. Both registers are 64 bits wide on the software side. In each of them the top bit is a control flag and not count data. On the counter, bit 63 is a sticky trap flag that is kept apart from the count. On the limit, bit 63 disables the interrupt.

A limit is armed only when its compare value is nonzero and its disable bit is clear. An armed limit fires once. It fires when the counter equals the compare value. If, at the time of the write, the compare value is already at or behind the count, it fires on the next enabled tick instead of waiting for the counter to wrap. A system typically places three copies of the block side by side, one for each of its tick sources, all running at a nominal 100 MHz tick rate.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset the count read returns 0x8000_0000_0000_0000, meaning the trap flag is set and the count is zero. The limit is disabled, nothing is armed, and `match_pulse` is low.
- R2: A count write loads bits 62:0 into the counter and stores bit 63 as the trap flag. From the next cycle, `cnt_rdata` returns the count in bits 62:0 and the flag in bit 63.
- R3: Without a count write, the counter adds one on each clock where `cnt_en` is high and holds otherwise. A count write takes precedence over the increment in the same cycle.
- R4: The counter wraps from 0x7FFF_FFFF_FFFF_FFFF to 0 and leaves the trap flag unchanged.
- R5: When an armed limit's compare value equals the counter in a cycle, `match_pulse` is high for the cycle after that edge.
- R6: A limit produces at most one pulse. After it fires, no further pulse occurs until the limit is written again.
- R7: A limit write whose bits 62:0 are zero arms nothing and never pulses.
- R8: A limit write with bit 63 set arms nothing and never pulses, even when the counter passes the compare value.
- R9: If an armed limit's compare value is less than or equal to the counter held at the write, the limit fires in the first cycle after the write in which `cnt_en` is high. The pulse follows on the next cycle, and no pulse occurs while `cnt_en` stays low.
- R10: A match in the same cycle as a count write or a limit write is still delivered. A limit written in that cycle is armed by its own rules and fires later on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Tick enable; the counter advances on each clock where this is high |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 64 | Count write data (bit 63 = trap flag) |
| lim_wr | input | 1 | Limit register write strobe |
| lim_wdata | input | 64 | Limit write data (bit 63 = interrupt disable) |
| cnt_rdata | output | 64 | Count read data (bit 63 = trap flag) |
| match_pulse | output | 1 | One-cycle soft-interrupt set pulse |

## Verification
The match event can coincide in one cycle with a software write. That write is either a count write that moves the counter away, or a limit write that replaces the armed limit. The bench watches the counter until it sits on the compare value and then drives the write in that same cycle. For the count write, it expects the pulse on the next cycle together with the newly written count. For the limit write, it expects the old limit's pulse first, then, on the following enabled cycle, a second pulse from the new limit, which is already behind the counter.

// File: rtl/tick_pkg.sv
package tick_pkg;
  parameter int unsigned TICK_REG_W = 64;
  localparam int unsigned TICK_VAL_W = TICK_REG_W - 1;
  localparam int unsigned TICK_FLAG_BIT = TICK_REG_W - 1;

  typedef logic [TICK_VAL_W-1:0] tick_val_t;
  typedef logic [TICK_REG_W-1:0] tick_reg_t;

  // next counter value, modulo 2^TICK_VAL_W
  function automatic tick_val_t tick_next(tick_val_t c);
    return c + tick_val_t'(1);
  endfunction

  // compare value at or behind the count: treated as already passed
  function automatic logic tick_behind(tick_val_t lim, tick_val_t c);
    return lim <= c;
  endfunction

  // a limit only arms when enabled and nonzero
  function automatic logic tick_armable(logic dis, tick_val_t v);
    return !dis && (v != '0);
  endfunction

  // software view of the count register
  function automatic tick_reg_t tick_read(logic flag, tick_val_t c);
    return {flag, c};
  endfunction
endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg
  import tick_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cnt_en,
  input  logic      cnt_wr,
  input  tick_reg_t cnt_wdata,
  output tick_val_t count_q,
  output logic      flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      flag_q  <= 1'b1;
    end else if (cnt_wr) begin
      count_q <= cnt_wdata[TICK_VAL_W-1:0];
      flag_q  <= cnt_wdata[TICK_FLAG_BIT];
    end else if (cnt_en) begin
      count_q <= tick_next(count_q);
    end
  end

  p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(cnt_wdata[TICK_VAL_W-1:0])) &&
               (flag_q == $past(cnt_wdata[TICK_FLAG_BIT])));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && cnt_en) |=> (count_q == $past(count_q) + tick_val_t'(1)) && $stable(flag_q));

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !cnt_en) |=> $stable(count_q) && $stable(flag_q));
endmodule

// File: rtl/tick_limit_reg.sv
module tick_limit_reg
  import tick_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lim_wr,
  input  tick_reg_t lim_wdata,
  input  tick_val_t count_q,
  input  logic      fire,
  output tick_val_t lim_val_q,
  output logic      dis_q,
  output logic      armed_q,
  output logic      late_q
);
  tick_val_t new_val;
  logic      new_dis;
  logic      new_arm;

  always_comb begin
    new_val = lim_wdata[TICK_VAL_W-1:0];
    new_dis = lim_wdata[TICK_FLAG_BIT];
    new_arm = tick_armable(new_dis, new_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_val_q <= '0;
      dis_q     <= 1'b1;
      armed_q   <= 1'b0;
      late_q    <= 1'b0;
    end else if (lim_wr) begin
      lim_val_q <= new_val;
      dis_q     <= new_dis;
      armed_q   <= new_arm;
      late_q    <= new_arm && tick_behind(new_val, count_q);
    end else if (fire) begin
      armed_q   <= 1'b0;
      late_q    <= 1'b0;
    end
  end

  p_zero_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && (lim_wdata[TICK_VAL_W-1:0] == '0)) |=> !armed_q);

  p_disabled_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && lim_wdata[TICK_FLAG_BIT]) |=> !armed_q && dis_q);

  p_disarm_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !lim_wr) |=> !armed_q);

  p_armed_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> !dis_q && (lim_val_q != '0));
endmodule

// File: rtl/tick_match_gen.sv
module tick_match_gen
  import tick_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cnt_en,
  input  tick_val_t count_q,
  input  tick_val_t lim_val_q,
  input  logic      armed_q,
  input  logic      late_q,
  output logic      fire,
  output logic      match_pulse
);
  logic hit_equal;
  logic hit_late;

  always_comb begin
    hit_equal = armed_q && !late_q && (count_q == lim_val_q);
    hit_late  = armed_q && late_q && cnt_en;
    fire      = hit_equal || hit_late;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_pulse <= 1'b0;
    else        match_pulse <= fire;
  end

  p_pulse_follows_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> match_pulse);

  p_pulse_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(armed_q));

  p_late_waits_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && late_q && !cnt_en) |=> !match_pulse);
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tick_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_en,
  input  logic                  cnt_wr,
  input  logic [TICK_REG_W-1:0] cnt_wdata,
  input  logic                  lim_wr,
  input  logic [TICK_REG_W-1:0] lim_wdata,
  output logic [TICK_REG_W-1:0] cnt_rdata,
  output logic                  match_pulse
);
  tick_val_t count_q;
  logic      flag_q;
  tick_val_t lim_val_q;
  logic      dis_q;
  logic      armed_q;
  logic      late_q;
  logic      fire;

  tick_count_reg u_count (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .count_q(count_q), .flag_q(flag_q)
  );

  tick_limit_reg u_limit (
    .clk(clk), .rst_n(rst_n), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
    .count_q(count_q), .fire(fire), .lim_val_q(lim_val_q), .dis_q(dis_q),
    .armed_q(armed_q), .late_q(late_q)
  );

  tick_match_gen u_match (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .count_q(count_q),
    .lim_val_q(lim_val_q), .armed_q(armed_q), .late_q(late_q),
    .fire(fire), .match_pulse(match_pulse)
  );

  assign cnt_rdata = tick_read(flag_q, count_q);

  p_read_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_rdata[TICK_FLAG_BIT] == $past(cnt_wdata[TICK_FLAG_BIT]));

  p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> !$past(dis_q));
endmodule

// File: tb/test_tick_compare_timer.sv
module test_tick_compare_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [63:0] cnt_wdata = '0;
  logic        lim_wr = 1'b0;
  logic [63:0] lim_wdata = '0;
  logic [63:0] cnt_rdata;
  logic        match_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

  always #2.5 clk = ~clk;

  tick_compare_timer i_tick_compare_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
    .cnt_rdata(cnt_rdata), .match_pulse(match_pulse)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input logic [63:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; cyc(); cnt_wr = 1'b0;
  endtask

  task automatic wr_lim(input logic [63:0] v);
    lim_wr = 1'b1; lim_wdata = v; cyc(); lim_wr = 1'b0;
  endtask

  // run n enabled cycles, count pulses, remember the count seen with the last pulse
  task automatic run(input int n, output int pulses, output logic [63:0] at);
    pulses = 0; at = '0;
    cnt_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (match_pulse) begin pulses++; at = cnt_rdata; end
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset read", cnt_rdata, TOP);
    check("R1 reset pulse", 64'(match_pulse), 64'd0);
    begin
      int p; logic [63:0] a;
      run(5, p, a);
      check("R1 nothing armed after reset", 64'(p), 64'd0);
      check("R3 counts from zero", cnt_rdata, TOP | 64'd5);
    end
  endtask

  task automatic t_count_write();
    wr_cnt(TOP | 64'h1234);
    check("R2 write with flag", cnt_rdata, TOP | 64'h1234);
    wr_cnt(64'h0000_0000_0000_00FF);
    check("R2 write without flag", cnt_rdata, 64'hFF);
  endtask

  task automatic t_increment();
    int p; logic [63:0] a;
    run(10, p, a);
    check("R3 ten ticks", cnt_rdata, 64'hFF + 64'd10);
    cyc(); cyc(); cyc();
    check("R3 hold when disabled", cnt_rdata, 64'hFF + 64'd10);
    cnt_en = 1'b1;
    wr_cnt(64'd77);
    cnt_en = 1'b0;
    check("R3 write beats increment", cnt_rdata, 64'd77);
  endtask

  task automatic t_wrap();
    int p; logic [63:0] a;
    wr_cnt(64'h7FFF_FFFF_FFFF_FFFE);
    run(2, p, a);
    check("R4 wrap flag clear", cnt_rdata, 64'd0);
    wr_cnt(64'hFFFF_FFFF_FFFF_FFFF);
    run(1, p, a);
    check("R4 wrap keeps flag", cnt_rdata, TOP);
  endtask

  task automatic t_equal_and_once();
    int p; logic [63:0] a;
    wr_cnt(64'd100);
    wr_lim(64'd105);
    run(20, p, a);
    check("R5 one pulse", 64'(p), 64'd1);
    check("R5 pulse follows match cycle", a, 64'd106);
    wr_cnt(64'd100);
    run(20, p, a);
    check("R6 no second pulse", 64'(p), 64'd0);
  endtask

  task automatic t_zero();
    int p; logic [63:0] a;
    wr_lim(64'd0);
    wr_cnt(64'h7FFF_FFFF_FFFF_FFFD);
    run(10, p, a);
    check("R7 zero limit silent", 64'(p), 64'd0);
  endtask

  task automatic t_disabled();
    int p; logic [63:0] a;
    wr_cnt(64'd45);
    wr_lim(TOP | 64'd50);
    run(15, p, a);
    check("R8 disabled limit silent", 64'(p), 64'd0);
  endtask

  task automatic t_late();
    int p; logic [63:0] a;
    wr_cnt(64'd200);
    wr_lim(64'd150);
    cyc(); check("R9 no pulse while idle", 64'(match_pulse), 64'd0);
    cyc(); check("R9 no pulse while idle", 64'(match_pulse), 64'd0);
    cnt_en = 1'b1; cyc(); cnt_en = 1'b0;
    check("R9 late pulse on first tick", 64'(match_pulse), 64'd1);
    check("R9 count at late pulse", cnt_rdata, 64'd201);
    wr_cnt(64'd300);
    wr_lim(64'd300);
    check("R9 equal treated as passed", 64'(match_pulse), 64'd0);
    run(5, p, a);
    check("R9 equal fires once", 64'(p), 64'd1);
    check("R9 equal fires on next tick", a, 64'd301);
  endtask

  task automatic t_coincide();
    wr_cnt(64'd500);
    wr_lim(64'd503);
    cnt_en = 1'b1;
    cyc(); cyc(); cyc();
    check("R10 at compare value", cnt_rdata, 64'd503);
    cnt_wr = 1'b1; cnt_wdata = 64'd10; cyc(); cnt_wr = 1'b0;
    check("R10 pulse with count write", 64'(match_pulse), 64'd1);
    check("R10 written count wins", cnt_rdata, 64'd10);
    cnt_en = 1'b0;
    wr_cnt(64'd600);
    wr_lim(64'd602);
    cnt_en = 1'b1;
    cyc(); cyc();
    check("R10 at compare value", cnt_rdata, 64'd602);
    lim_wr = 1'b1; lim_wdata = 64'd100; cyc(); lim_wr = 1'b0;
    check("R10 old limit pulse", 64'(match_pulse), 64'd1);
    cyc();
    check("R10 new late limit pulse", 64'(match_pulse), 64'd1);
    cyc();
    check("R10 then quiet", 64'(match_pulse), 64'd0);
    cnt_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_count_write();
    t_increment();
    t_wrap();
    t_equal_and_once();
    t_zero();
    t_disabled();
    t_late();
    t_coincide();
    finish_run();
  end
endmodule